// File: doc/BRIEF.md
# Interrupt Acknowledge Bus Sequencer

This block sits in the bus interface unit of a processor. It watches the interrupt request line and the interrupt-enable flag. When both are active it takes the bus and runs a fixed pair of locked bus cycles. An interrupt controller on the bus decodes these cycles as an acknowledge and puts its service-routine vector on the data bus during the second one. The sequencer latches the low byte of that vector and presents it with a one-cycle valid strobe. The byte returned in the first cycle is discarded.

Each cycle has one address-strobe state (T1) followed by one or more T2 states, which repeat until the ready input is sampled low. The status lines code an acknowledge with all three low. The lock output covers both cycles and the idle gap between them. The address and byte-enable pattern is fixed: byte address 4 for the first cycle and 0 for the second, with the low byte enabled and the high byte disabled. When cascade mode is enabled, a 3-bit cascade selector is placed on upper address bits for the duration of each cycle. A request from another bus master for the bus is only granted while the sequencer is idle.

Top module: `intack_seq`

## Requirements
- R1: A sequence starts only when `irq_req_i` and `ien_i` are both high while the sequencer is idle. If either is low, `strobe_n_o` and `lock_n_o` stay high.
- R2: Each acknowledge cycle drives `strobe_n_o` low for exactly one clock (T1). It is followed by T2 states that repeat while `ready_n_i` is sampled high, and the cycle ends on the first edge in T2 where `ready_n_i` is low.
- R3: During T1 and T2 of both cycles, `mio_n_o`, `dc_n_o` and `wr_n_o` are all 0. Outside the cycles they are all 1. `refresh_n_o` is always 1.
- R4: `lock_n_o` is 0 from the first cycle's T1 through the last T2 of the second cycle, including the gap between them, and 1 otherwise.
- R5: `hold_ack_o` rises only on the edge after an idle clock with `hold_req_i` high, so it is never granted during a sequence. While the hold request or grant is high, no sequence starts.
- R6: `next_addr_n_i` has no effect on any output.
- R7: In both cycles `bhe_n_o`=1 and `ble_n_o`=0. `addr_o` is 4 in the first cycle and 0 in the second, apart from the cascade field. Outside the cycles `ble_n_o`=1 and `addr_o`=0.
- R8: When `cas_en_i` is 1, `addr_o[18:16]` carries the cascade selector during T1 and T2. When it is 0, that field is 0.
- R9: The cascade selector is latched on entry to each T1 and removed in the idle gap. A value changed between the cycles therefore appears in the second cycle.
- R10: The low byte of `data_i` at the second cycle's ready edge appears on `vec_o`, with `vec_valid_o` high for exactly one clock. Data taken in the first cycle never reaches `vec_o`.
- R11: Once the first cycle has started, the second cycle always completes, even if `irq_req_i` or `ien_i` drops.
- R12: At least one idle clock (the default is one), with `strobe_n_o`=1 and status lines high, separates the two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 1 | Interrupt request |
| ien_i | input | 1 | Interrupt-enable flag |
| hold_req_i | input | 1 | Bus request from another master |
| ready_n_i | input | 1 | Active-low cycle termination |
| next_addr_n_i | input | 1 | Pipelining request, ignored |
| cas_en_i | input | 1 | Cascade-on-address enable |
| cas_sel_i | input | CAS_W | Cascade selector |
| data_i | input | DATA_W | Data bus |
| strobe_n_o | output | 1 | Address strobe, active low |
| mio_n_o | output | 1 | Memory/IO status |
| dc_n_o | output | 1 | Data/control status |
| wr_n_o | output | 1 | Write/read status |
| refresh_n_o | output | 1 | Refresh indicator, held inactive |
| lock_n_o | output | 1 | Bus lock, active low |
| bhe_n_o | output | 1 | High byte enable, active low |
| ble_n_o | output | 1 | Low byte enable, active low |
| addr_o | output | ADDR_W | Byte address |
| hold_ack_o | output | 1 | Bus grant to another master |
| vec_o | output | VEC_W | Captured interrupt vector |
| vec_valid_o | output | 1 | One-clock vector strobe |

## Verification
The hardest conditions to reach are those that occur inside a running pair: a hold request that arrives mid-sequence, an interrupt request that is withdrawn after the first strobe, and a cascade selector that changes in the one-clock gap. The directed tasks follow the bus state by counting clocks from the start edge. They inject each of these disturbances at a chosen state (T1 of the first cycle or the gap) while the number of wait states is varied. They then compare every bus output in each state against the expected pattern.

// File: rtl/intack_pkg.sv
package intack_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_C1_T1 = 3'd1,
      ST_C1_T2 = 3'd2,
      ST_GAP   = 3'd3,
      ST_C2_T1 = 3'd4,
      ST_C2_T2 = 3'd5
   } ack_state_e;

   function automatic logic in_first(input ack_state_e s);
      return (s == ST_C1_T1) || (s == ST_C1_T2);
   endfunction

   function automatic logic in_second(input ack_state_e s);
      return (s == ST_C2_T1) || (s == ST_C2_T2);
   endfunction

   function automatic logic is_t1(input ack_state_e s);
      return (s == ST_C1_T1) || (s == ST_C2_T1);
   endfunction
endpackage

// File: rtl/intack_fsm.sv
module intack_fsm
   import intack_pkg::*;
#(
   parameter int GAP_CYCLES = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       irq_req_i,
   input  logic       ien_i,
   input  logic       hold_req_i,
   input  logic       ready_n_i,
   output ack_state_e state_o,
   output logic       load_cas_o,
   output logic       vec_take_o,
   output logic       hold_ack_o
);
   localparam int GW = $clog2(GAP_CYCLES + 1);
   localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYCLES - 1);

   ack_state_e      state_q, state_d;
   logic [GW-1:0]   gap_cnt_q;
   logic            start;

   assign start = (state_q == ST_IDLE) && !hold_req_i && !hold_ack_o
                  && irq_req_i && ien_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (start) state_d = ST_C1_T1;
         ST_C1_T1: state_d = ST_C1_T2;
         ST_C1_T2: if (!ready_n_i) state_d = ST_GAP;
         ST_GAP:   if (gap_cnt_q == GAP_LAST) state_d = ST_C2_T1;
         ST_C2_T1: state_d = ST_C2_T2;
         ST_C2_T2: if (!ready_n_i) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         gap_cnt_q  <= '0;
         hold_ack_o <= 1'b0;
      end else begin
         state_q    <= state_d;
         gap_cnt_q  <= (state_q == ST_GAP) ? gap_cnt_q + 1'b1 : '0;
         hold_ack_o <= (state_q == ST_IDLE) && hold_req_i;
      end
   end

   assign state_o    = state_q;
   assign load_cas_o = is_t1(state_d) && (state_d != state_q);
   assign vec_take_o = (state_q == ST_C2_T2) && !ready_n_i;

   p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE && !(irq_req_i && ien_i)) |=> (state_q == ST_IDLE));
   p_t1_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_C1_T1) |=> (state_q == ST_C1_T2));
   p_grant_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hold_ack_o |-> (state_q == ST_IDLE));
   p_gap_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_C1_T2 && !ready_n_i) |=> (state_q == ST_GAP));
   p_pair_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_GAP && gap_cnt_q == GAP_LAST) |=> (state_q == ST_C2_T1));
endmodule

// File: rtl/intack_addr.sv
module intack_addr
   import intack_pkg::*;
#(
   parameter int ADDR_W      = 26,
   parameter int CAS_W       = 3,
   parameter int CAS_LSB     = 16,
   parameter bit CAS_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ack_state_e        state_i,
   input  logic              load_cas_i,
   input  logic              cas_en_i,
   input  logic [CAS_W-1:0]  cas_sel_i,
   output logic              strobe_n_o,
   output logic              mio_n_o,
   output logic              dc_n_o,
   output logic              wr_n_o,
   output logic              lock_n_o,
   output logic              bhe_n_o,
   output logic              ble_n_o,
   output logic [ADDR_W-1:0] addr_o
);
   localparam logic [ADDR_W-1:0] FIRST_ADDR = ADDR_W'(4);

   logic              c1, c2, active;
   logic [CAS_W-1:0]  cas_q;

   assign c1     = in_first(state_i);
   assign c2     = in_second(state_i);
   assign active = c1 || c2;

   generate
      if (CAS_SUPPORT) begin : g_cas
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cas_q <= '0;
            else if (load_cas_i) cas_q <= cas_en_i ? cas_sel_i : '0;
         end
      end else begin : g_nocas
         logic unused_cas;
         assign unused_cas = load_cas_i ^ cas_en_i ^ (^cas_sel_i) ^ clk ^ rst_n;
         assign cas_q = '0;
      end
   endgenerate

   always_comb begin
      addr_o = '0;
      if (c1) addr_o = FIRST_ADDR;
      if (active) addr_o[CAS_LSB +: CAS_W] = cas_q;
   end

   assign strobe_n_o = !is_t1(state_i);
   assign mio_n_o    = !active;
   assign dc_n_o     = !active;
   assign wr_n_o     = !active;
   assign lock_n_o   = (state_i == ST_IDLE);
   assign bhe_n_o    = 1'b1;
   assign ble_n_o    = !active;

   p_cas_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (load_cas_i && !cas_en_i) |=> (addr_o[CAS_LSB +: CAS_W] == '0));
   p_gap_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_GAP) |-> (addr_o == '0 && strobe_n_o));
endmodule

// File: rtl/intack_vec.sv
module intack_vec #(
   parameter int DATA_W = 16,
   parameter int VEC_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [VEC_W-1:0]  vec_o,
   output logic              vec_valid_o
);
   generate
      if (DATA_W > VEC_W) begin : g_spare
         logic unused_hi;
         assign unused_hi = ^data_i[DATA_W-1:VEC_W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_o       <= '0;
         vec_valid_o <= 1'b0;
      end else begin
         vec_valid_o <= take_i;
         if (take_i) vec_o <= data_i[VEC_W-1:0];
      end
   end

   p_vec_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid_o |=> !vec_valid_o);
   p_vec_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !take_i |=> $stable(vec_o));
endmodule

// File: rtl/intack_seq.sv
module intack_seq
   import intack_pkg::*;
#(
   parameter int ADDR_W      = 26,
   parameter int DATA_W      = 16,
   parameter int VEC_W       = 8,
   parameter int CAS_W       = 3,
   parameter int CAS_LSB     = 16,
   parameter int GAP_CYCLES  = 1,
   parameter bit CAS_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_req_i,
   input  logic              ien_i,
   input  logic              hold_req_i,
   input  logic              ready_n_i,
   input  logic              next_addr_n_i,
   input  logic              cas_en_i,
   input  logic [CAS_W-1:0]  cas_sel_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              strobe_n_o,
   output logic              mio_n_o,
   output logic              dc_n_o,
   output logic              wr_n_o,
   output logic              refresh_n_o,
   output logic              lock_n_o,
   output logic              bhe_n_o,
   output logic              ble_n_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              hold_ack_o,
   output logic [VEC_W-1:0]  vec_o,
   output logic              vec_valid_o
);
   generate
      if (CAS_LSB < 3 || CAS_LSB + CAS_W > ADDR_W) begin : g_bad_cas
         $error("cascade field must lie above bit 2 and inside the address");
      end
      if (VEC_W > DATA_W || VEC_W < 1) begin : g_bad_vec
         $error("vector width must fit the data bus");
      end
      if (GAP_CYCLES < 1) begin : g_bad_gap
         $error("at least one idle clock is needed between the cycles");
      end
   endgenerate

   ack_state_e state;
   logic       load_cas, vec_take;
   logic       unused_na;

   assign unused_na   = next_addr_n_i;
   assign refresh_n_o = 1'b1;

   intack_fsm #(.GAP_CYCLES(GAP_CYCLES)) fsm_i (
      .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req_i), .ien_i(ien_i),
      .hold_req_i(hold_req_i), .ready_n_i(ready_n_i), .state_o(state),
      .load_cas_o(load_cas), .vec_take_o(vec_take), .hold_ack_o(hold_ack_o)
   );

   intack_addr #(
      .ADDR_W(ADDR_W), .CAS_W(CAS_W), .CAS_LSB(CAS_LSB), .CAS_SUPPORT(CAS_SUPPORT)
   ) addr_i (
      .clk(clk), .rst_n(rst_n), .state_i(state), .load_cas_i(load_cas),
      .cas_en_i(cas_en_i), .cas_sel_i(cas_sel_i), .strobe_n_o(strobe_n_o),
      .mio_n_o(mio_n_o), .dc_n_o(dc_n_o), .wr_n_o(wr_n_o), .lock_n_o(lock_n_o),
      .bhe_n_o(bhe_n_o), .ble_n_o(ble_n_o), .addr_o(addr_o)
   );

   intack_vec #(.DATA_W(DATA_W), .VEC_W(VEC_W)) vec_i (
      .clk(clk), .rst_n(rst_n), .take_i(vec_take), .data_i(data_i),
      .vec_o(vec_o), .vec_valid_o(vec_valid_o)
   );

   p_status_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_n_o |-> (!mio_n_o && !dc_n_o && !wr_n_o && refresh_n_o));
   p_lock_cover_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ble_n_o |-> !lock_n_o);
   p_no_grant_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hold_ack_o |-> lock_n_o);
   p_bytes_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_n_o |-> (bhe_n_o && !ble_n_o));
endmodule

// File: tb/intack_seq_tb_top.sv
`timescale 1ns/1ps
module intack_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq = 1'b0, ien = 1'b0, hold_req = 1'b0, ready_n = 1'b1;
   logic        na_n = 1'b1, cas_en = 1'b0;
   logic [2:0]  cas_sel = '0;
   logic [15:0] data = '0;
   logic        strobe_n, mio_n, dc_n, wr_n, refresh_n, lock_n, bhe_n, ble_n;
   logic [25:0] addr;
   logic        hold_ack, vec_valid;
   logic [7:0]  vec;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   intack_seq dut_i (
      .clk(clk), .rst_n(rst_n), .irq_req_i(irq), .ien_i(ien), .hold_req_i(hold_req),
      .ready_n_i(ready_n), .next_addr_n_i(na_n), .cas_en_i(cas_en), .cas_sel_i(cas_sel),
      .data_i(data), .strobe_n_o(strobe_n), .mio_n_o(mio_n), .dc_n_o(dc_n), .wr_n_o(wr_n),
      .refresh_n_o(refresh_n), .lock_n_o(lock_n), .bhe_n_o(bhe_n), .ble_n_o(ble_n),
      .addr_o(addr), .hold_ack_o(hold_ack), .vec_o(vec), .vec_valid_o(vec_valid)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); @(negedge clk);
   endtask

   function automatic logic [31:0] cas_field(input logic ce, input logic [2:0] c);
      return ce ? {13'd0, c, 16'd0} : 32'd0;
   endfunction

   // bus pattern inside an acknowledge cycle (R2 R3 R4 R5 R7 R8)
   task automatic chk_bus(input string tag, input logic ads, input logic [31:0] a);
      chk({tag, " R2 strobe"}, strobe_n, ads);
      chk({tag, " R3 status"}, {mio_n, dc_n, wr_n, refresh_n}, 4'b0001);
      chk({tag, " R4 lock"}, lock_n, 1'b0);
      chk({tag, " R7 bytes"}, {bhe_n, ble_n}, 2'b10);
      chk({tag, " R7 R8 addr"}, addr, a);
      chk({tag, " R5 no grant"}, hold_ack, 1'b0);
   endtask

   task automatic run_pair(input string tag, input int w1, input int w2,
                           input logic [15:0] d1, input logic [15:0] d2,
                           input logic ce, input logic [2:0] c1, input logic [2:0] c2,
                           input bit drop, input bit hold_mid);
      @(negedge clk);
      irq = 1; ien = 1; cas_en = ce; cas_sel = c1; ready_n = 1;
      step();
      chk_bus({tag, " c1 T1"}, 1'b0, 32'd4 | cas_field(ce, c1));
      if (drop) begin irq = 0; ien = 0; end
      if (hold_mid) hold_req = 1;
      step();
      repeat (w1) begin chk_bus({tag, " c1 wait"}, 1'b1, 32'd4 | cas_field(ce, c1)); step(); end
      chk_bus({tag, " c1 T2"}, 1'b1, 32'd4 | cas_field(ce, c1));
      ready_n = 0; data = d1;
      step();
      ready_n = 1; irq = 0; cas_sel = c2; data = 16'h0;
      chk({tag, " R12 gap strobe"}, strobe_n, 1'b1);
      chk({tag, " R12 gap status"}, {mio_n, dc_n, wr_n}, 3'b111);
      chk({tag, " R4 gap lock"}, lock_n, 1'b0);
      chk({tag, " R9 gap addr"}, addr, 32'd0);
      step();
      chk_bus({tag, " R11 c2 T1"}, 1'b0, cas_field(ce, c2));
      step();
      repeat (w2) begin chk_bus({tag, " c2 wait"}, 1'b1, cas_field(ce, c2)); step(); end
      chk_bus({tag, " R9 c2 T2"}, 1'b1, cas_field(ce, c2));
      ready_n = 0; data = d2;
      step();
      ready_n = 1; data = d1;
      chk({tag, " R10 valid"}, vec_valid, 1'b1);
      chk({tag, " R10 vec"}, vec, d2[7:0]);
      chk({tag, " R4 unlock"}, lock_n, 1'b1);
      chk({tag, " R7 idle ble"}, {ble_n, addr}, {1'b1, 26'd0});
      step();
      chk({tag, " R10 pulse"}, vec_valid, 1'b0);
      chk({tag, " R10 keep"}, vec, d2[7:0]);
      chk({tag, " R1 no restart"}, strobe_n, 1'b1);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R4 reset lock", lock_n, 1'b1);
      chk("R2 reset strobe", strobe_n, 1'b1);
      chk("R3 reset status", {mio_n, dc_n, wr_n, refresh_n}, 4'b1111);
      chk("R10 reset valid", vec_valid, 1'b0);
      chk("R5 reset grant", hold_ack, 1'b0);
   endtask

   task automatic t_gate();
      @(negedge clk); irq = 1; ien = 0;
      repeat (3) begin step(); chk("R1 ien low", {strobe_n, lock_n}, 2'b11); end
      irq = 0; ien = 1;
      repeat (3) begin step(); chk("R1 irq low", {strobe_n, lock_n}, 2'b11); end
      ien = 0;
   endtask

   task automatic t_hold();
      @(negedge clk); hold_req = 1;
      step();
      chk("R5 idle grant", hold_ack, 1'b1);
      irq = 1; ien = 1;
      repeat (3) begin step(); chk("R5 held off", {strobe_n, lock_n}, 2'b11); end
      irq = 0; hold_req = 0;
      step();
      chk("R5 release", hold_ack, 1'b0);
      run_pair("R5 mid", 1, 0, 16'h1111, 16'h2233, 1'b0, 3'd0, 3'd0, 1'b0, 1'b1);
      chk("R5 grant after pair", hold_ack, 1'b1);
      hold_req = 0;
      step();
      chk("R5 grant drop", hold_ack, 1'b0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      t_reset();
      t_gate();
      run_pair("R2 basic", 0, 0, 16'h0055, 16'h00A7, 1'b0, 3'd5, 3'd2, 1'b0, 1'b0);
      run_pair("R2 waits", 2, 3, 16'hBEEF, 16'h12C4, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0);
      run_pair("R8 cascade", 1, 0, 16'h0099, 16'h0042, 1'b1, 3'd6, 3'd1, 1'b0, 1'b0);
      run_pair("R9 cas same", 0, 2, 16'h0001, 16'h00FF, 1'b1, 3'd7, 3'd7, 1'b0, 1'b0);
      na_n = 0;
      run_pair("R6 na low", 1, 1, 16'h0033, 16'h0081, 1'b0, 3'd0, 3'd0, 1'b0, 1'b0);
      na_n = 1;
      run_pair("R11 drop", 0, 1, 16'h0077, 16'h0018, 1'b1, 3'd3, 3'd4, 1'b1, 1'b0);
      t_hold();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 50000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog R2 actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule